// File: doc/BRIEF.md
# Packed BCD Adjust Unit

This unit repairs an 8-bit accumulator after a plain binary add or subtract of two packed BCD bytes, so that each 4-bit half again holds a decimal digit from 0 to 9. It takes the raw byte together with the carry and auxiliary (half) carry left by that arithmetic step. A mode select tells it whether the step was an addition or a subtraction. It returns the corrected byte and a fresh set of condition flags.

The unit is used in the execute stage of a datapath, straight after the ALU operation it corrects. A valid strobe marks each request. The corrected byte and the flags appear on registered outputs exactly one clock later, together with a one-cycle output valid. Requests may be issued on consecutive cycles.

Both correction decisions are taken from the byte and carry as they arrive, not from any partly corrected value. The low-digit step also has its own carry-out rule, which watches whether the whole byte crosses its top or bottom end.

Top module: `bcd_adjust_unit`

## Requirements
- R1: The low correction applies when the input byte's bits [3:0], read as a number, exceed 9, or when auxIn is 1. auxOut is 1 exactly when the low correction applies, and 0 otherwise.
- R2: With subSel = 0 (adjust after addition), the low correction adds 0x06 to the byte. When it applies, the carry it provides is 1 if the input byte is above 0xF9 or carryIn is 1.
- R3: With subSel = 1 (adjust after subtraction), the low correction subtracts 0x06 from the byte. When it applies, the carry it provides is 1 if the input byte is below 0x06 or carryIn is 1.
- R4: The high correction applies when the original input byte is above 0x99 or the original carryIn is 1. It adds 0x60 (subSel = 0) or subtracts 0x60 (subSel = 1) after any low correction, and it forces carryOut to 1.
- R5: When neither correction applies, result equals the input byte and carryOut and auxOut are both 0.
- R6: zeroOut is 1 exactly when the final result is 0x00. signOut equals bit 7 of the final result.
- R7: parityOut is 1 when the final result has an even number of 1 bits, and 0 when it has an odd number.
- R8: overflowOut is always 0.
- R9: All byte arithmetic wraps modulo 256.
- R10: Result and flags appear one clock edge after the edge that samples inValid = 1. outValid is high for exactly that one cycle per request, and back-to-back requests give back-to-back results.
- R11: A synchronous reset (rst = 1 at a clock edge) clears outValid, result and every flag output to 0, even if inValid is high at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe for one adjust |
| subSel | input | 1 | 0 = adjust after addition, 1 = adjust after subtraction |
| accIn | input | 8 | Raw accumulator byte |
| carryIn | input | 1 | Carry flag from the preceding arithmetic |
| auxIn | input | 1 | Auxiliary (nibble) carry from the preceding arithmetic |
| outValid | output | 1 | One-cycle marker for a new result |
| result | output | 8 | Corrected byte |
| carryOut | output | 1 | Decimal carry/borrow out |
| auxOut | output | 1 | Low correction applied |
| zeroOut | output | 1 | Result is zero |
| signOut | output | 1 | Bit 7 of the result |
| parityOut | output | 1 | Even number of 1 bits in the result |
| overflowOut | output | 1 | Always 0 |

## Verification
Every output of this unit is due on the cycle after the edge that samples the request. No other latency applies. The driver tags each expected item with the cycle number at which its request is sampled. The monitor looks just after each rising edge. It demands that an item seen with outValid high was issued exactly one edge earlier. It treats an outValid with no pending item as a fault, and also treats as a fault an item whose due cycle has passed without a result. Requests are sent both back to back and with idle gaps, so that the one-cycle pulse and the pipelined case are both exercised.

// File: rtl/bcd_adj_pkg.sv
`timescale 1ns/1ps
package bcd_adj_pkg;

  localparam int ACC_W = 8;
  localparam int NIB_W = ACC_W / 2;

  typedef logic [ACC_W-1:0] acc_t;
  typedef logic [NIB_W-1:0] nib_t;

  // largest legal decimal digit in one nibble
  localparam nib_t DIGIT_MAX = nib_t'(9);
  // correction added to / taken from a single digit position
  localparam acc_t LOW_STEP  = acc_t'(6);
  localparam acc_t HIGH_STEP = acc_t'(6) << NIB_W;
  // both digits at their maximum (0x99)
  localparam acc_t PAIR_MAX  = {DIGIT_MAX, DIGIT_MAX};
  // highest byte that survives the low step in add mode without wrapping (0xF9)
  localparam acc_t ADD_EDGE  = '1 - LOW_STEP;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic subMode;
    logic lowFix;
    logic highFix;
    logic carryOut;
    logic auxOut;
  } adjStrobe_t;

endpackage

// File: rtl/bcd_adj_ctrl.sv
`timescale 1ns/1ps
module bcd_adj_ctrl
  import bcd_adj_pkg::*;
(
  input  logic       inValid,
  input  logic       subSel,
  input  acc_t       accIn,
  input  logic       carryIn,
  input  logic       auxIn,
  output adjStrobe_t strobe
);

  nib_t lowDigit;
  logic lowNeeded;
  logic highNeeded;
  logic lowCarryAdd;
  logic lowCarrySub;
  logic lowCarry;

  assign lowDigit = accIn[NIB_W-1:0];

  // both decisions use the byte and carry as received
  always_comb begin
    lowNeeded   = (lowDigit > DIGIT_MAX) || auxIn;
    highNeeded  = (accIn > PAIR_MAX) || carryIn;
    lowCarryAdd = (accIn > ADD_EDGE) || carryIn;
    lowCarrySub = (accIn < LOW_STEP) || carryIn;
    lowCarry    = subSel ? lowCarrySub : lowCarryAdd;
  end

  always_comb begin
    strobe.load     = inValid;
    strobe.subMode  = subSel;
    strobe.lowFix   = lowNeeded;
    strobe.highFix  = highNeeded;
    strobe.auxOut   = lowNeeded;
    if (highNeeded)
      strobe.carryOut = 1'b1;
    else if (lowNeeded)
      strobe.carryOut = lowCarry;
    else
      strobe.carryOut = 1'b0;
  end

endmodule

// File: rtl/bcd_adj_dp.sv
`timescale 1ns/1ps
module bcd_adj_dp
  import bcd_adj_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  adjStrobe_t strobe,
  input  acc_t       accIn,
  output logic       outValid,
  output acc_t       result,
  output logic       carryOut,
  output logic       auxOut,
  output logic       zeroOut,
  output logic       signOut,
  output logic       parityOut,
  output logic       overflowOut
);

  acc_t lowStage;
  acc_t highStage;
  logic nextZero;
  logic nextSign;
  logic nextParity;

  always_comb begin
    lowStage = accIn;
    if (strobe.lowFix)
      lowStage = strobe.subMode ? (accIn - LOW_STEP) : (accIn + LOW_STEP);
    highStage = lowStage;
    if (strobe.highFix)
      highStage = strobe.subMode ? (lowStage - HIGH_STEP) : (lowStage + HIGH_STEP);
  end

  always_comb begin
    nextZero   = (highStage == '0);
    nextSign   = highStage[ACC_W-1];
    nextParity = ~^highStage;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid    <= 1'b0;
      result      <= '0;
      carryOut    <= 1'b0;
      auxOut      <= 1'b0;
      zeroOut     <= 1'b0;
      signOut     <= 1'b0;
      parityOut   <= 1'b0;
      overflowOut <= 1'b0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) begin
        result      <= highStage;
        carryOut    <= strobe.carryOut;
        auxOut      <= strobe.auxOut;
        zeroOut     <= nextZero;
        signOut     <= nextSign;
        parityOut   <= nextParity;
        overflowOut <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bcd_adjust_unit.sv
`timescale 1ns/1ps
module bcd_adjust_unit
  import bcd_adj_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             subSel,
  input  logic [ACC_W-1:0] accIn,
  input  logic             carryIn,
  input  logic             auxIn,
  output logic             outValid,
  output logic [ACC_W-1:0] result,
  output logic             carryOut,
  output logic             auxOut,
  output logic             zeroOut,
  output logic             signOut,
  output logic             parityOut,
  output logic             overflowOut
);

  adjStrobe_t strobe;

  bcd_adj_ctrl u_ctrl (
    .inValid (inValid),
    .subSel  (subSel),
    .accIn   (accIn),
    .carryIn (carryIn),
    .auxIn   (auxIn),
    .strobe  (strobe)
  );

  bcd_adj_dp u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .accIn       (accIn),
    .outValid    (outValid),
    .result      (result),
    .carryOut    (carryOut),
    .auxOut      (auxOut),
    .zeroOut     (zeroOut),
    .signOut     (signOut),
    .parityOut   (parityOut),
    .overflowOut (overflowOut)
  );

endmodule

// File: rtl/bcd_adjust_checker.sv
`timescale 1ns/1ps
module bcd_adjust_checker
  import bcd_adj_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic             subSel,
  input logic [ACC_W-1:0] accIn,
  input logic             carryIn,
  input logic             auxIn,
  input logic             outValid,
  input logic [ACC_W-1:0] result,
  input logic             carryOut,
  input logic             auxOut,
  input logic             zeroOut,
  input logic             signOut,
  input logic             parityOut,
  input logic             overflowOut
);

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_valid_single_r10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_no_aux_r1: assert property (@(posedge clk) disable iff (rst)
    (inValid && (accIn[NIB_W-1:0] <= DIGIT_MAX) && !auxIn) |=> !auxOut);

  p_aux_set_r1: assert property (@(posedge clk) disable iff (rst)
    (inValid && auxIn) |=> auxOut);

  p_high_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && ((accIn > PAIR_MAX) || carryIn)) |=> carryOut);

  p_pass_through_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && !carryIn && !auxIn && (accIn <= PAIR_MAX) && (accIn[NIB_W-1:0] <= DIGIT_MAX))
      |=> (result == $past(accIn)) && !carryOut);

  p_zero_flag_r6: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (zeroOut == (result == '0)));

  p_parity_r7: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (parityOut == (($countones(result) % 2) == 0)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !overflowOut);

  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> !outValid && (result == '0) && !carryOut);

endmodule

bind bcd_adjust_unit bcd_adjust_checker u_chk (.*);

// File: tb/bcd_adjust_unit_test.sv
`timescale 1ns/1ps
module bcd_adjust_unit_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic       subSel = 1'b0;
  logic [7:0] accIn = 8'h00;
  logic       carryIn = 1'b0;
  logic       auxIn = 1'b0;
  logic       outValid;
  logic [7:0] result;
  logic       carryOut, auxOut, zeroOut, signOut, parityOut, overflowOut;

  always #2 clk = ~clk;

  bcd_adjust_unit uut (
    .clk(clk), .rst(rst), .inValid(inValid), .subSel(subSel), .accIn(accIn),
    .carryIn(carryIn), .auxIn(auxIn), .outValid(outValid), .result(result),
    .carryOut(carryOut), .auxOut(auxOut), .zeroOut(zeroOut), .signOut(signOut),
    .parityOut(parityOut), .overflowOut(overflowOut)
  );

  typedef struct {
    int         cyc;
    logic [7:0] res;
    logic       cy, af, zf, sf, pf;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   nChecks = 0;
  int   nFail = 0;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // expected values straight from the requirements
  function automatic exp_t model(input logic [7:0] a, input logic cy,
                                 input logic af, input logic sub);
    exp_t e;
    logic [7:0] r;
    logic c, low, high;
    low  = (a[3:0] > 4'd9) || af;
    high = (a > 8'h99) || cy;
    r = a;
    c = 1'b0;
    if (low) begin
      r = sub ? r - 8'h06 : r + 8'h06;
      c = sub ? ((a < 8'h06) || cy) : ((a > 8'hF9) || cy);
    end
    if (high) begin
      r = sub ? r - 8'h60 : r + 8'h60;
      c = 1'b1;
    end
    e.cyc = 0;
    e.res = r;
    e.cy  = c;
    e.af  = low;
    e.zf  = (r == 8'h00);
    e.sf  = r[7];
    e.pf  = ($countones(r) % 2) == 0;
    return e;
  endfunction

  task automatic send(input logic [7:0] a, input logic cy, input logic af,
                      input logic sub);
    exp_t e;
    @(negedge clk);
    inValid = 1'b1;
    accIn   = a;
    carryIn = cy;
    auxIn   = af;
    subSel  = sub;
    e = model(a, cy, af, sub);
    e.cyc = cyc;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      accIn   = 8'hA5;
      carryIn = 1'b1;
      auxIn   = 1'b1;
    end
  endtask

  // monitor: sample just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      if (!rst) begin
        if (q.size() != 0 && q[0].cyc + 1 < cyc) begin
          check(1'b0, "R10", "result missing at due cycle", 0, q[0].cyc + 1);
          void'(q.pop_front());
        end
        if (outValid) begin
          if (q.size() == 0) begin
            check(1'b0, "R10", "outValid with no pending request", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(e.cyc + 1 == cyc, "R10", "latency cycle", cyc, e.cyc + 1);
            check(result == e.res, "R2/R3/R4/R5/R9", "result", result, e.res);
            check(carryOut == e.cy, "R2/R3/R4/R5", "carryOut", carryOut, e.cy);
            check(auxOut == e.af, "R1", "auxOut", auxOut, e.af);
            check(zeroOut == e.zf, "R6", "zeroOut", zeroOut, e.zf);
            check(signOut == e.sf, "R6", "signOut", signOut, e.sf);
            check(parityOut == e.pf, "R7", "parityOut", parityOut, e.pf);
            check(overflowOut == 1'b0, "R8", "overflowOut", overflowOut, 0);
          end
        end
      end
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WATCHDOG", "run did not finish", cyc, 0);
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: outputs cleared while held in reset
    check(outValid == 0 && result == 0 && carryOut == 0 && auxOut == 0 &&
          zeroOut == 0 && signOut == 0 && parityOut == 0 && overflowOut == 0,
          "R11", "outputs during reset", {outValid, result}, 0);
    rst = 1'b0;
    idle(2);

    // directed add-adjust cases
    send(8'h0F, 0, 0, 0);  // R1 R2: 0x15, no carry
    idle(1);
    send(8'h9A, 0, 0, 0);  // R4: 0xA0 then +0x60 wraps to 0x00, zero, carry (R9)
    send(8'hFA, 0, 0, 0);  // R2: low carry from >0xF9, wrap, high step -> 0x60
    send(8'h45, 0, 0, 0);  // R5: untouched
    send(8'h12, 0, 1, 0);  // R1: aux forces low step -> 0x18
    send(8'h25, 1, 0, 0);  // R4: carry forces high step -> 0x85, sign
    idle(2);
    // directed subtract-adjust cases
    send(8'h0F, 0, 0, 1);  // R3: 0x09, no carry
    send(8'h03, 0, 1, 1);  // R3: below 0x06 -> carry, 0xFD
    send(8'hA0, 0, 0, 1);  // R4: high step only -> 0x40
    send(8'h00, 1, 0, 1);  // R4 R9: 0xA0 with carry
    send(8'h66, 0, 1, 1);  // R3: 0x60, no carry
    idle(3);

    // R10: back-to-back sweep of every byte, flag pair and mode
    for (int m = 0; m < 8; m++) begin
      for (int a = 0; a < 256; a++) begin
        send(8'(a), m[0], m[1], m[2]);
      end
      idle(m % 3);
    end
    idle(3);

    // R11: reset wins over a request sampled at the same edge
    send(8'h77, 0, 0, 0);
    idle(2);
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b1;
    accIn = 8'h55;
    @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    check(outValid == 0 && result == 0 && carryOut == 0 && auxOut == 0 &&
          zeroOut == 0 && signOut == 0 && parityOut == 0,
          "R11", "outputs after mid-run reset", {outValid, result}, 0);
    idle(3);
    check(q.size() == 0, "R10", "pending items left", q.size(), 0);
    done = 1'b1;
    summary();
  end

endmodule